// File: doc/BRIEF.md
# Serial Sampling ADC Host Controller

This block sits on the host side of a serial 12-bit sampling analog-to-digital converter. When the host asks for a sample, the block sends a timed low pulse on the convert line. It then follows the converter's ready flag, which is low while a conversion runs. It collects the 12-bit two's-complement result, MSB first, and presents it as a signed word with a one-cycle valid strobe.

The block reads the converter in one of two ways, selected by `mode_ext`.

- **Converter-clocked read** (`mode_ext` = 0): the converter supplies the serial clock and sends a word while the conversion is running. That word is the result of the conversion before. The block keeps chip select low, synchronizes the converter clock and data, and shifts in one bit on each rising edge of the synchronized clock. It closes the frame when ready rises.
- **Host-clocked read** (`mode_ext` = 1): the block waits for the conversion to end. It then lowers chip select and generates twelve clock periods from a programmable divider of the system clock, sampling the data line on each rising edge. After that it raises chip select again.

Top module: `sadc_host`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `adc_conv_n` is 1, `sample_vld` and `frame_err` are 0 and `adc_sclk_out` is 0. With `mode_ext` = 0, `adc_cs_n` is 0.
- R2: A convert pulse drives `adc_conv_n` low for exactly CONV_LOW system cycles (default 4, which is 40 ns at 100 MHz).
- R3: A request is accepted only when the controller is idle and the synchronized `adc_rdy` is high. A request that arrives at any other time is held and starts a conversion once both conditions are true.
- R4: With `mode_ext` = 0, the block shifts `adc_sdata` in on each rising edge of `adc_sclk_in` while `adc_rdy` is low, first bit into the MSB. When `adc_rdy` rises after exactly 12 bits, `sample` carries the 12 bits as a signed two's-complement value and `sample_vld` pulses.
- R5: With `mode_ext` = 0, the first frame that closes after reset, or after any change of `mode_ext`, is dropped. It raises neither `sample_vld` nor `frame_err`.
- R6: With `mode_ext` = 0, a frame that closes with fewer or more than 12 bits pulses `frame_err` and produces no `sample_vld`.
- R7: With `mode_ext` = 1, after `adc_rdy` rises following a convert pulse, `adc_cs_n` goes low and exactly 12 clock periods appear on `adc_sclk_out`. Each period is high for `clk_div` cycles and low for `clk_div` cycles; a value of 0 acts as 1. `adc_sclk_out` is never high while `adc_cs_n` is high.
- R8: With `mode_ext` = 1, `adc_sdata` is sampled as `adc_sclk_out` rises, MSB first. After the 12th period `adc_cs_n` returns high and `sample_vld` pulses with the signed word.
- R9: `sample_vld` and `frame_err` each last one cycle and are never high together.
- R10: With `mode_ext` = 0, `adc_cs_n` stays low and `adc_sclk_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ext | input | 1 | 1: host-clocked read, 0: converter-clocked read |
| clk_div | input | DIV_W | Half-period of the generated serial clock, in system cycles |
| req | input | 1 | Conversion request pulse |
| adc_conv_n | output | 1 | Convert line, active-low pulse |
| adc_rdy | input | 1 | Converter ready flag, low while converting |
| adc_sclk_in | input | 1 | Serial clock from the converter (converter-clocked read) |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_sclk_out | output | 1 | Serial clock to the converter (host-clocked read) |
| adc_cs_n | output | 1 | Chip select, active low |
| sample | output | 12 | Signed result |
| sample_vld | output | 1 | One-cycle strobe for `sample` |
| frame_err | output | 1 | One-cycle strobe for a frame with a wrong bit count |

## Verification
The bench switches modes between conversions and checks that the first converter-clocked frame after each switch is swallowed. A controller without the drop would output a stale or meaningless word.

It sends frames of 11 and 13 bits. A design that only counts up to twelve would accept a truncated word or let a 13th bit shift the MSB out.

It sends requests while the converter reports busy and while a conversion is in flight. A design that drops such a request would miss a conversion. A design that ignores the ready flag would pulse the convert line mid-conversion.

Host-clocked reads run at two divider settings. The bench counts the clock pulses and their high time, and checks that chip select covers every pulse. It also feeds codes at both ends of the signed range, which exposes a shift in the wrong direction or an unsigned result.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int RES_W   = 12;
    localparam int CNT_W   = 4;
    localparam int CNT_MAX = RES_W + 1;

    typedef logic signed [RES_W-1:0] sample_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT_LOW,
        ST_WAIT_HIGH,
        ST_READ
    } ctl_state_e;

    typedef struct packed {
        logic    vld;
        logic    err;
        sample_t data;
    } result_t;

    // Saturating bit counter step, stops one past a full word.
    function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
        return (c == CNT_W'(CNT_MAX)) ? c : c + CNT_W'(1);
    endfunction

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[i] <= RST_VAL;
                else if (i == 0)
                    chain[i] <= d;
                else
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sadc_int_rx.sv
module sadc_int_rx
    import sadc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    mode_chg,
    input  logic    sclk_s,
    input  logic    sdata_s,
    input  logic    rdy_s,
    output result_t res
);
    logic             sclk_q, rdy_q, drop;
    logic [CNT_W-1:0] nbits;
    logic [RES_W-1:0] shreg;
    logic             sclk_rise, rdy_rise, rdy_fall;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign rdy_rise  = rdy_s & ~rdy_q;
    assign rdy_fall  = ~rdy_s & rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            rdy_q  <= 1'b1;
            drop   <= 1'b1;
            nbits  <= '0;
            shreg  <= '0;
            res    <= '0;
        end else begin
            sclk_q  <= sclk_s;
            rdy_q   <= rdy_s;
            res.vld <= 1'b0;
            res.err <= 1'b0;
            if (mode_chg) begin
                drop  <= 1'b1;
                nbits <= '0;
            end else if (en) begin
                if (rdy_fall) begin
                    nbits <= '0;
                end else if (!rdy_s && sclk_rise) begin
                    shreg <= {shreg[RES_W-2:0], sdata_s};
                    nbits <= cnt_step(nbits);
                end
                if (rdy_rise) begin
                    if (drop)
                        drop <= 1'b0;
                    else if (nbits == CNT_W'(RES_W)) begin
                        res.vld  <= 1'b1;
                        res.data <= sample_t'(shreg);
                    end else
                        res.err  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sadc_ext_rx.sv
module sadc_ext_rx
    import sadc_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] div,
    input  logic             sdata,
    output logic             sclk,
    output logic             active,
    output result_t          res
);
    logic [DIV_W-1:0] tick, tick_last;
    logic [CNT_W-1:0] nbits;
    logic [RES_W-1:0] shreg;

    assign tick_last = (div == '0) ? '0 : div - DIV_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk   <= 1'b0;
            active <= 1'b0;
            tick   <= '0;
            nbits  <= '0;
            shreg  <= '0;
            res    <= '0;
        end else begin
            res.vld <= 1'b0;
            res.err <= 1'b0;
            if (start) begin
                active <= 1'b1;
                sclk   <= 1'b0;
                tick   <= '0;
                nbits  <= '0;
            end else if (active) begin
                if (tick == tick_last) begin
                    tick <= '0;
                    if (!sclk) begin
                        sclk  <= 1'b1;
                        shreg <= {shreg[RES_W-2:0], sdata};
                        nbits <= cnt_step(nbits);
                    end else begin
                        sclk <= 1'b0;
                        if (nbits == CNT_W'(RES_W)) begin
                            active   <= 1'b0;
                            res.vld  <= 1'b1;
                            res.data <= sample_t'(shreg);
                        end
                    end
                end else begin
                    tick <= tick + DIV_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sadc_host.sv
module sadc_host
    import sadc_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int CONV_LOW    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mode_ext,
    input  logic [DIV_W-1:0]        clk_div,
    input  logic                    req,
    output logic                    adc_conv_n,
    input  logic                    adc_rdy,
    input  logic                    adc_sclk_in,
    input  logic                    adc_sdata,
    output logic                    adc_sclk_out,
    output logic                    adc_cs_n,
    output logic signed [RES_W-1:0] sample,
    output logic                    sample_vld,
    output logic                    frame_err
);
    localparam int LOW_W = $clog2(CONV_LOW + 1);

    ctl_state_e       state;
    logic [LOW_W-1:0] low_cnt;
    logic             pend, mode_q, mode_chg;
    logic             rdy_s, sclk_s, sdata_s;
    logic             ext_start, rd_active;
    result_t          int_res, ext_res;

    sadc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rdy (
        .clk(clk), .rst(rst), .d(adc_rdy), .q(rdy_s));
    sadc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst(rst), .d(adc_sclk_in), .q(sclk_s));
    sadc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdata (
        .clk(clk), .rst(rst), .d(adc_sdata), .q(sdata_s));

    assign mode_chg  = mode_ext ^ mode_q;
    assign ext_start = (state == ST_WAIT_HIGH) && rdy_s && mode_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            low_cnt    <= '0;
            pend       <= 1'b0;
            mode_q     <= 1'b0;
            adc_conv_n <= 1'b1;
        end else begin
            mode_q <= mode_ext;
            if (req)
                pend <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (pend && rdy_s) begin
                        state      <= ST_CONV;
                        adc_conv_n <= 1'b0;
                        low_cnt    <= '0;
                        pend       <= req;
                    end
                end
                ST_CONV: begin
                    low_cnt <= low_cnt + LOW_W'(1);
                    if (low_cnt == LOW_W'(CONV_LOW - 1)) begin
                        adc_conv_n <= 1'b1;
                        state      <= ST_WAIT_LOW;
                    end
                end
                ST_WAIT_LOW: begin
                    if (!rdy_s)
                        state <= ST_WAIT_HIGH;
                end
                ST_WAIT_HIGH: begin
                    if (rdy_s)
                        state <= mode_ext ? ST_READ : ST_IDLE;
                end
                ST_READ: begin
                    if (!rd_active)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    sadc_int_rx u_int_rx (
        .clk(clk), .rst(rst), .en(!mode_ext), .mode_chg(mode_chg),
        .sclk_s(sclk_s), .sdata_s(sdata_s), .rdy_s(rdy_s), .res(int_res));

    sadc_ext_rx #(.DIV_W(DIV_W)) u_ext_rx (
        .clk(clk), .rst(rst), .start(ext_start), .div(clk_div),
        .sdata(adc_sdata), .sclk(adc_sclk_out), .active(rd_active),
        .res(ext_res));

    assign adc_cs_n   = mode_ext ? ~rd_active : 1'b0;
    assign sample_vld = int_res.vld | ext_res.vld;
    assign sample     = ext_res.vld ? ext_res.data : int_res.data;
    assign frame_err  = int_res.err;
endmodule

// File: rtl/sadc_host_chk.sv
module sadc_host_chk #(
    parameter int CONV_LOW = 4
) (
    input logic clk,
    input logic rst,
    input logic mode_ext,
    input logic adc_conv_n,
    input logic adc_sclk_out,
    input logic adc_cs_n,
    input logic sample_vld,
    input logic frame_err
);
    logic [15:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || adc_conv_n)
            low_run <= '0;
        else
            low_run <= low_run + 16'd1;
    end

    assert_conv_width_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_conv_n) |-> (low_run == 16'(CONV_LOW)));

    assert_sclk_under_cs_R7: assert property (@(posedge clk) disable iff (rst)
        adc_sclk_out |-> !adc_cs_n);

    assert_no_start_in_read_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_ext && $fell(adc_conv_n)) |-> adc_cs_n);

    assert_vld_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        sample_vld |=> !sample_vld);

    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

    assert_vld_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(sample_vld && frame_err));

    assert_int_no_sclk_R10: assert property (@(posedge clk) disable iff (rst)
        (!mode_ext && $past(!mode_ext) && !$past(adc_sclk_out)) |-> !adc_sclk_out);
endmodule

bind sadc_host sadc_host_chk #(.CONV_LOW(CONV_LOW)) u_chk (
    .clk(clk), .rst(rst), .mode_ext(mode_ext), .adc_conv_n(adc_conv_n),
    .adc_sclk_out(adc_sclk_out), .adc_cs_n(adc_cs_n),
    .sample_vld(sample_vld), .frame_err(frame_err));

// File: tb/sadc_host_test.sv
module sadc_host_test;
    localparam int CONV_LOW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_ext = 1'b0;
    logic [7:0]  clk_div = 8'd2;
    logic        req = 1'b0;
    logic        adc_rdy = 1'b1;
    logic        adc_sclk_in = 1'b0;
    logic        adc_sdata = 1'b0;
    logic        adc_conv_n, adc_sclk_out, adc_cs_n, sample_vld, frame_err;
    logic signed [11:0] sample;

    int n_checks = 0, n_fail = 0;
    int vld_cnt = 0, err_cnt = 0, conv_cnt = 0, sclk_cnt = 0, cs_viol = 0;
    int low_w = 0, last_low_w = 0, hi_w = 0, last_hi_w = 0;
    int last_sample = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sadc_host #(.DIV_W(8), .CONV_LOW(CONV_LOW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .mode_ext(mode_ext), .clk_div(clk_div), .req(req),
        .adc_conv_n(adc_conv_n), .adc_rdy(adc_rdy), .adc_sclk_in(adc_sclk_in),
        .adc_sdata(adc_sdata), .adc_sclk_out(adc_sclk_out), .adc_cs_n(adc_cs_n),
        .sample(sample), .sample_vld(sample_vld), .frame_err(frame_err));

    // Port observer
    logic conv_prev = 1'b1, sclk_prev = 1'b0;
    always @(posedge clk) begin
        if (!rst) begin
            if (sample_vld) begin vld_cnt++; last_sample = int'(sample); end
            if (frame_err) err_cnt++;
            if (conv_prev && !adc_conv_n) conv_cnt++;
            if (!adc_conv_n) low_w++;
            else begin if (!conv_prev) last_low_w = low_w; low_w = 0; end
            if (!sclk_prev && adc_sclk_out) sclk_cnt++;
            if (adc_sclk_out) hi_w++;
            else begin if (sclk_prev) last_hi_w = hi_w; hi_w = 0; end
            if (adc_sclk_out && adc_cs_n) cs_viol++;
            conv_prev = adc_conv_n;
            sclk_prev = adc_sclk_out;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic pulse_req();
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
    endtask

    task automatic int_frame(input int nbits, input logic [11:0] code, input bit do_req);
        if (do_req) pulse_req();
        while (adc_conv_n) @(negedge clk);
        while (!adc_conv_n) @(negedge clk);
        adc_rdy = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            adc_sdata = (i < 12) ? code[11-i] : 1'b0;
            adc_sclk_in = 1'b0;
            repeat (3) @(negedge clk);
            adc_sclk_in = 1'b1;
            repeat (3) @(negedge clk);
        end
        adc_sclk_in = 1'b0;
        repeat (3) @(negedge clk);
        adc_rdy = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic ext_frame(input logic [11:0] code, input bit do_req);
        if (do_req) pulse_req();
        while (adc_conv_n) @(negedge clk);
        while (!adc_conv_n) @(negedge clk);
        adc_rdy = 1'b0;
        repeat (8) @(negedge clk);
        adc_sdata = code[11];
        adc_rdy = 1'b1;
        for (int i = 0; i < 12; i++) begin
            while (!adc_sclk_out) @(negedge clk);
            while (adc_sclk_out) @(negedge clk);
            if (i < 11) adc_sdata = code[10-i];
        end
        repeat (4) @(negedge clk);
    endtask

    // {ext, expect_valid, code}
    localparam logic [13:0] VEC [8] = '{
        {1'b0, 1'b0, 12'h123},
        {1'b0, 1'b1, 12'h800},
        {1'b0, 1'b1, 12'h7FF},
        {1'b1, 1'b1, 12'hA5A},
        {1'b1, 1'b1, 12'h001},
        {1'b0, 1'b0, 12'hFFF},
        {1'b0, 1'b1, 12'h555},
        {1'b1, 1'b1, 12'h000}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        int v0, s0, c0, e0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 conv_n in reset", adc_conv_n, 1);
        chk("R1 vld in reset", sample_vld, 0);
        chk("R1 err in reset", frame_err, 0);
        chk("R1 sclk_out in reset", adc_sclk_out, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 conv_n after reset", adc_conv_n, 1);
        chk("R10 cs_n low in converter-clocked mode", adc_cs_n, 0);

        for (int k = 0; k < 8; k++) begin
            if (mode_ext != VEC[k][13]) begin
                mode_ext = VEC[k][13];
                repeat (3) @(negedge clk);
            end
            v0 = vld_cnt; s0 = sclk_cnt;
            if (VEC[k][13]) ext_frame(VEC[k][11:0], 1'b1);
            else            int_frame(12, VEC[k][11:0], 1'b1);
            if (VEC[k][13]) begin
                chk("R7 twelve sclk periods", sclk_cnt - s0, 12);
                chk("R8 ext valid count", vld_cnt - v0, 1);
                chk("R8 ext sample", last_sample, int'($signed(VEC[k][11:0])));
                chk("R8 cs_n high after read", adc_cs_n, 1);
            end else begin
                chk("R10 no sclk_out in converter-clocked mode", sclk_cnt - s0, 0);
                chk(VEC[k][12] ? "R4 int valid count" : "R5 dropped frame",
                    vld_cnt - v0, int'(VEC[k][12]));
                if (VEC[k][12])
                    chk("R4 int sample", last_sample, int'($signed(VEC[k][11:0])));
            end
            chk("R2 conv low width", last_low_w, CONV_LOW);
        end
        chk("R7 cs_n never high under sclk", cs_viol, 0);
        chk("R7 sclk high width div=2", last_hi_w, 2);

        // R6 short and long frames
        mode_ext = 1'b0;
        repeat (3) @(negedge clk);
        int_frame(12, 12'h321, 1'b1);          // dropped after mode change
        v0 = vld_cnt; e0 = err_cnt;
        int_frame(11, 12'h0F0, 1'b1);
        chk("R6 11-bit frame error", err_cnt - e0, 1);
        chk("R6 11-bit frame no valid", vld_cnt - v0, 0);
        int_frame(13, 12'h0F0, 1'b1);
        chk("R6 13-bit frame error", err_cnt - e0, 2);
        chk("R6 13-bit frame no valid", vld_cnt - v0, 0);
        int_frame(12, 12'h9AB, 1'b1);
        chk("R4 valid after errored frames", last_sample, int'($signed(12'h9AB)));
        chk("R5 drop does not raise error", err_cnt - e0, 2);

        // R3 request held while converter busy
        adc_rdy = 1'b0;
        repeat (4) @(negedge clk);
        c0 = conv_cnt;
        pulse_req();
        repeat (20) @(negedge clk);
        chk("R3 no convert while busy", conv_cnt - c0, 0);
        adc_rdy = 1'b1;
        int_frame(12, 12'h246, 1'b0);
        chk("R3 held request served", conv_cnt - c0, 1);
        chk("R4 sample after held request", last_sample, int'($signed(12'h246)));

        // R3 request during conversion, host-clocked, divider 3
        mode_ext = 1'b1;
        clk_div = 8'd3;
        repeat (3) @(negedge clk);
        c0 = conv_cnt; v0 = vld_cnt;
        pulse_req();
        repeat (2) @(negedge clk);
        pulse_req();
        ext_frame(12'h3C3, 1'b0);
        ext_frame(12'hC3C, 1'b0);
        chk("R3 second request served", conv_cnt - c0, 2);
        chk("R8 two words", vld_cnt - v0, 2);
        chk("R8 last word", last_sample, int'($signed(12'hC3C)));
        chk("R7 sclk high width div=3", last_hi_w, 3);

        // R7 divider 0 acts as 1
        clk_div = 8'd0;
        s0 = sclk_cnt;
        ext_frame(12'h801, 1'b1);
        chk("R7 div=0 high width", last_hi_w, 1);
        chk("R7 div=0 period count", sclk_cnt - s0, 12);
        chk("R8 div=0 sample", last_sample, int'($signed(12'h801)));
        chk("R7 cs_n never high under sclk", cs_viol, 0);

        report();
    end
endmodule